// File: doc/BRIEF.md
# Two-Level Control Decoder for a Single-Cycle Core

This block is the purely combinational control unit of a single-cycle processor that runs a small load/store subset: word load, word store, branch-if-equal, unconditional jump, and the register-register operations add, subtract, and, or and set-on-less-than. It takes the fetched 32-bit instruction word and, in the same cycle, produces every steering and enable signal the datapath needs.

Decoding happens in two stages. A primary decoder looks only at the opcode field, bits [31:26]. It produces eight single-bit controls and a 2-bit ALU class. A secondary decoder combines that class with the function field, bits [5:0], to select a 3-bit ALU operation. The two stages share nothing except the class. Bits [25:6] hold the register numbers and the shift amount, and the block ignores them.

Top module: `cpu_ctl_decoder`

## Requirements
- R1: Opcode 0 (register-register) drives reg_dst=1 and reg_wr=1, with alu_class=2'b10 and all other single-bit controls at 0.
- R2: Opcode 35 (load word) drives alu_src=1, mem_to_reg=1, reg_wr=1 and mem_rd=1, with alu_class=2'b00 and the rest at 0.
- R3: Opcode 43 (store word) drives alu_src=1 and mem_wr=1, with alu_class=2'b00 and the rest at 0.
- R4: Opcode 4 (branch-if-equal) drives branch=1 only, with alu_class=2'b01.
- R5: Opcode 2 (jump) drives jump=1 only, with alu_class=2'b00.
- R6: Any other opcode drives all eight single-bit controls to 0 and alu_class=2'b00.
- R7: alu_class 2'b00 gives alu_op=3'b010 (add) and 2'b01 gives alu_op=3'b110 (subtract), whatever the function field holds.
- R8: With alu_class 2'b10, the function field selects alu_op as follows: 32 gives 010 (add), 34 gives 110 (sub), 36 gives 000 (and), 37 gives 001 (or), 42 gives 111 (slt).
- R9: With alu_class 2'b10 and any other function value, alu_op falls back to 3'b010 (add).
- R10: Instruction bits [25:6] have no effect on any output.
- R11: At most one of mem_rd, mem_wr, branch and jump is high. reg_wr is never high together with mem_wr, branch or jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word; opcode in [31:26], function in [5:0] |
| reg_dst | output | 1 | Destination register taken from bits [15:11] rather than [20:16] |
| alu_src | output | 1 | Second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | Register write data comes from memory instead of the ALU |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch on ALU zero |
| jump | output | 1 | Unconditional jump |
| alu_class | output | 2 | Operation class passed from the primary to the secondary decoder |
| alu_op | output | 3 | ALU operation code |

## Verification
Every supported opcode is crossed with every supported function code. This separates the cases where the function field must steer the ALU (opcode 0) from the cases where it must be ignored (load, store, branch, jump). Opcodes outside the set, including neighbours of valid codes such as 3, 5, 34 and 63, show that no enable leaks out of an undefined encoding. Function codes outside the set, such as 0, 33 and 63, exercise the add fallback. Each pair is also repeated with different random values in bits [25:6], which shows the register and shift fields have no effect.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FUN_W   = 6;
  localparam int CLS_W   = 2;
  localparam int ALU_W   = 3;
  localparam int OPC_LSB = INSTR_W - OPC_W;

  localparam logic [OPC_W-1:0] OPC_RRR  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_LDW  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STW  = 6'd43;

  localparam logic [FUN_W-1:0] FUN_ADD  = 6'd32;
  localparam logic [FUN_W-1:0] FUN_SUB  = 6'd34;
  localparam logic [FUN_W-1:0] FUN_AND  = 6'd36;
  localparam logic [FUN_W-1:0] FUN_OR   = 6'd37;
  localparam logic [FUN_W-1:0] FUN_SLT  = 6'd42;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADDR = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_FUNC = 2'b10,
    CLS_RSVD = 2'b11
  } alu_class_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic reg_dst;
    logic alu_src;
    logic mem_to_reg;
    logic reg_wr;
    logic mem_rd;
    logic mem_wr;
    logic branch;
    logic jump;
  } ctl_bits_t;
endpackage

// File: rtl/cpu_ctl_main_dec.sv
module cpu_ctl_main_dec
  import cpu_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctl_bits_t        ctl,
  output alu_class_e       cls
);
  always_comb begin
    ctl = '0;
    cls = CLS_ADDR;
    unique case (opcode)
      OPC_RRR: begin
        ctl.reg_dst = 1'b1;
        ctl.reg_wr  = 1'b1;
        cls         = CLS_FUNC;
      end
      OPC_LDW: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_wr     = 1'b1;
        ctl.mem_rd     = 1'b1;
      end
      OPC_STW: begin
        ctl.alu_src = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        cls        = CLS_CMP;
      end
      OPC_JMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end

  // R11
  always_comb begin
    excl_side_effect_chk: assert ($onehot0({ctl.mem_rd, ctl.mem_wr, ctl.branch, ctl.jump}))
      else $error("more than one memory/flow control high");
  end

  // R11
  always_comb begin
    no_wr_with_store_chk: assert (!(ctl.reg_wr && (ctl.mem_wr || ctl.branch || ctl.jump)))
      else $error("register write alongside store/branch/jump");
  end
endmodule

// File: rtl/cpu_ctl_alu_dec.sv
module cpu_ctl_alu_dec
  import cpu_ctl_pkg::*;
(
  input  alu_class_e       cls,
  input  logic [FUN_W-1:0] funct,
  output alu_op_e          op
);
  alu_op_e fun_op;

  always_comb begin
    unique case (funct)
      FUN_ADD: fun_op = ALU_ADD;
      FUN_SUB: fun_op = ALU_SUB;
      FUN_AND: fun_op = ALU_AND;
      FUN_OR:  fun_op = ALU_OR;
      FUN_SLT: fun_op = ALU_SLT;
      default: fun_op = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (cls)
      CLS_CMP:  op = ALU_SUB;
      CLS_FUNC: op = fun_op;
      default:  op = ALU_ADD;
    endcase
  end

  // R8
  always_comb begin
    legal_alu_op_chk: assert (op inside {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT})
      else $error("ALU code outside the defined set");
  end
endmodule

// File: rtl/cpu_ctl_decoder.sv
module cpu_ctl_decoder
  import cpu_ctl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               reg_dst,
  output logic               alu_src,
  output logic               mem_to_reg,
  output logic               reg_wr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               branch,
  output logic               jump,
  output logic [CLS_W-1:0]   alu_class,
  output logic [ALU_W-1:0]   alu_op
);
  logic [OPC_W-1:0] opc_fld;
  logic [FUN_W-1:0] fun_fld;
  ctl_bits_t        ctl;
  alu_class_e       cls;
  alu_op_e          op;

  assign opc_fld = instr[INSTR_W-1:OPC_LSB];
  assign fun_fld = instr[FUN_W-1:0];

  cpu_ctl_main_dec u_main (
    .opcode (opc_fld),
    .ctl    (ctl),
    .cls    (cls)
  );

  cpu_ctl_alu_dec u_alu (
    .cls   (cls),
    .funct (fun_fld),
    .op    (op)
  );

  assign reg_dst    = ctl.reg_dst;
  assign alu_src    = ctl.alu_src;
  assign mem_to_reg = ctl.mem_to_reg;
  assign reg_wr     = ctl.reg_wr;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign branch     = ctl.branch;
  assign jump       = ctl.jump;
  assign alu_class  = cls;
  assign alu_op     = op;

  // R4 R7
  always_comb begin
    branch_subtracts_chk: assert (!ctl.branch || op == ALU_SUB)
      else $error("branch without subtract");
  end

  // R2 R3 R7
  always_comb begin
    mem_addr_adds_chk: assert (!(ctl.mem_rd || ctl.mem_wr) || op == ALU_ADD)
      else $error("memory access without address add");
  end
endmodule

// File: tb/cpu_ctl_decoder_test.sv
module cpu_ctl_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic        reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump;
  logic [1:0]  alu_class;
  logic [2:0]  alu_op;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  cpu_ctl_decoder uut (
    .instr(instr), .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .branch(branch),
    .jump(jump), .alu_class(alu_class), .alu_op(alu_op)
  );

  // expected: {reg_dst,alu_src,mem_to_reg,reg_wr,mem_rd,mem_wr,branch,jump,class[1:0],op[2:0]}
  function automatic logic [12:0] model(input int opc, input int fn);
    logic [7:0] b;
    logic [1:0] c;
    logic [2:0] o;
    b = 8'b0; c = 2'b00;
    if      (opc == 0)  begin b = 8'b1001_0000; c = 2'b10; end
    else if (opc == 35) begin b = 8'b0111_1000; end
    else if (opc == 43) begin b = 8'b0100_0100; end
    else if (opc == 4)  begin b = 8'b0000_0010; c = 2'b01; end
    else if (opc == 2)  begin b = 8'b0000_0001; end
    if (c == 2'b01) o = 3'b110;
    else if (c == 2'b10) begin
      case (fn)
        32: o = 3'b010;
        34: o = 3'b110;
        36: o = 3'b000;
        37: o = 3'b001;
        42: o = 3'b111;
        default: o = 3'b010;
      endcase
    end else o = 3'b010;
    return {b, c, o};
  endfunction

  function automatic string req_of(input int opc, input int fn);
    if (opc == 0)
      return (fn inside {32, 34, 36, 37, 42}) ? "R1/R8" : "R1/R9";
    if (opc == 35) return "R2/R7";
    if (opc == 43) return "R3/R7";
    if (opc == 4)  return "R4/R7";
    if (opc == 2)  return "R5/R7";
    return "R6/R7";
  endfunction

  task automatic apply(input int opc, input int fn, input logic [19:0] mid, input string tag);
    logic [12:0] got, exp;
    @(posedge clk);
    instr <= {opc[5:0], mid, fn[5:0]};
    @(negedge clk);
    got = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, jump, alu_class, alu_op};
    exp = model(opc, fn);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d fn=%0d mid=%h got=%b exp=%b", tag, opc, fn, mid, got, exp);
    end
    // R11 checked at the ports too
    n_chk++;
    if (!$onehot0({mem_rd, mem_wr, branch, jump}) || (reg_wr && (mem_wr || branch || jump))) begin
      n_bad++;
      $display("FAIL R11 op=%0d got=%b exp=exclusive enables", opc, got);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int opcs[12] = '{0, 35, 43, 4, 2, 1, 3, 5, 8, 15, 34, 63};
    int fns[8]   = '{32, 34, 36, 37, 42, 0, 33, 63};
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    // initial state: all-zero word decodes as register-register with fallback add (R1, R9)
    apply(0, 0, 20'd0, "R1/R9 idle word");
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 8; j++)
        apply(opcs[i], fns[j], 20'd0, req_of(opcs[i], fns[j]));
    // R10: the middle fields vary, the outputs must not
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 3; k++) begin
          logic [19:0] m;
          m = (k == 0) ? 20'hFFFFF : 20'($urandom);
          apply(opcs[i], fns[j], m, "R10");
        end
    // every opcode value once (R6 coverage), function 42
    for (int o = 0; o < 64; o++)
      apply(o, 42, 20'($urandom), req_of(o, 42));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule